// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on to a usable state. When reset is released it drives the memory's command, address, bank and clock-enable pins through a fixed start-up order. First it holds no-operation for a long settling time. It then precharges every bank, issues two auto refreshes and writes the mode register. After the mode-register delay it raises a completion flag. The memory controller watches that flag and takes over the pins once it is high.

The settling time, the precharge period and the refresh period are given in nanoseconds and the clock period in picoseconds. The block turns each of them into a whole number of clock cycles, rounding up. The mode-register delay is given directly in cycles. The mode word comes in as an input and is sampled in the cycle the load is issued. The bits that select reserved and test behaviour (11, 10, 8 and 7) are forced to zero on the way out.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst` is high the command pins show NOP (`{cs_n,ras_n,cas_n,we_n}` = 4'b0111), `cke` is low, `done` is low and `addr` and `ba` are zero.
- R2: `cke` is low in the cycle in which reset is released (cycle 0) and high from the first rising edge after release onward.
- R3: With HOLD = ceil(HOLD_NS*1000/CLK_PS), cycles 0 to HOLD-1 carry NOP only, and PRECHARGE (4'b0010) is issued in cycle HOLD.
- R4: The precharge carries `addr[10]` = 1 (all banks), with every other address bit and `ba` at zero.
- R5: The first AUTO REFRESH (4'b0001) comes exactly TRP = ceil(TRP_NS*1000/CLK_PS) cycles after PRECHARGE. The second comes exactly TRFC = ceil(TRFC_NS*1000/CLK_PS) cycles after the first. No other refresh is issued.
- R6: LOAD MODE REGISTER (4'b0000) comes exactly TRFC cycles after the second refresh. It carries `mode_word` with bits 11, 10, 8 and 7 cleared on `addr`, and `ba` = 0.
- R7: `done` rises exactly TMRD_CYC cycles after LOAD MODE REGISTER and stays high until the next reset.
- R8: Every cycle that carries none of the four issued commands carries NOP with zero address, including all cycles after `done`.
- R9: A delay that is not a whole multiple of the clock period is rounded up to the next whole cycle.
- R10: A reset applied part-way through the order abandons it. The block then restarts the whole order from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_word | input | 12 | Mode-register value to load |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Memory address pins |
| ba | output | BANK_W | Bank address pins |
| done | output | 1 | Initialization complete, sticky until reset |

## Verification
The hardest conditions to reach from the ports are the exact spacing between commands when a delay rounds up, and a reset that lands in the middle of the order. The bench overrides the delays with small values so the whole order fits in about seventy cycles. One of those values, a refresh period of 75 ns against a 10 ns clock, does not divide evenly and must round up to 8 cycles. The bench also cuts a second run short with a reset inside the refresh window, then checks that the restarted run places every command at the same offsets as the first run.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CLK_PS   = 10000,
  parameter int HOLD_NS  = 100000,
  parameter int TRP_NS   = 20,
  parameter int TRFC_NS  = 70,
  parameter int TMRD_CYC = 2,
  parameter int ADDR_W   = 12,
  parameter int BANK_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       mode_word,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              done
);
  localparam int HOLD_RAW = (HOLD_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int TRP_RAW  = (TRP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int TRFC_RAW = (TRFC_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int TRP_CYC  = (TRP_RAW < 1) ? 1 : TRP_RAW;
  localparam int TRFC_CYC = (TRFC_RAW < 1) ? 1 : TRFC_RAW;
  localparam int MRD_CYC  = (TMRD_CYC < 1) ? 1 : TMRD_CYC;
  localparam int GAP_MAX  = (HOLD_CYC > TRFC_CYC) ? ((HOLD_CYC > TRP_CYC) ? HOLD_CYC : TRP_CYC)
                                                  : ((TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC);
  localparam int GAP_MAX2 = (GAP_MAX > MRD_CYC) ? GAP_MAX : MRD_CYC;
  localparam int CW       = $clog2(GAP_MAX2 + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;
  localparam logic [11:0] MODE_KEEP = 12'h27F;

  typedef enum logic [2:0] {W_PRE, W_REF1, W_REF2, W_LMR, W_FIN, FIN} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          fire;
  logic [3:0]    cmd;

  always_comb begin
    case (phase)
      W_PRE:          target = CW'(HOLD_CYC);
      W_REF1:         target = CW'(TRP_CYC);
      W_REF2, W_LMR:  target = CW'(TRFC_CYC);
      W_FIN:          target = CW'(MRD_CYC);
      default:        target = '0;
    endcase
  end

  assign fire = (phase != FIN) && (cnt == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= W_PRE;
      cnt   <= '0;
      cke   <= 1'b0;
    end else begin
      cke <= 1'b1;
      if (fire) begin
        phase <= phase_t'(phase + 3'd1);
        cnt   <= CW'(1);
      end else if (phase != FIN) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    cmd  = C_NOP;
    addr = '0;
    if (fire) begin
      case (phase)
        W_PRE:  begin cmd = C_PRE; addr[10] = 1'b1; end
        W_REF1: cmd = C_REF;
        W_REF2: cmd = C_REF;
        W_LMR:  begin cmd = C_LMR; addr[11:0] = mode_word & MODE_KEEP; end
        default: cmd = C_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba   = '0;
  assign done = (phase == FIN) || (fire && phase == W_FIN);
endmodule

module sdram_powerup_seq_chk #(
  parameter int HOLD_CYC = 1,
  parameter int ADDR_W   = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);
  logic [3:0] cmd;
  int         since;
  int         refs;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= 0;
      refs  <= 0;
    end else begin
      if (since < HOLD_CYC) since <= since + 1;
      if (cmd == 4'b0001) refs <= refs + 1;
    end
  end

  a_r3_hold_only_nop: assert property (@(posedge clk) disable iff (rst)
    (since < HOLD_CYC) |-> (cmd == 4'b0111));
  a_r4_precharge_all: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> addr[10]);
  a_r5_two_refreshes: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0001) |-> (refs < 2));
  a_r6_reserved_clear: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (addr[11:10] == 2'b00 && addr[8:7] == 2'b00));
  a_r6_refs_before_load: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (refs == 2));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  a_r7_gap_after_load: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |=> (cmd == 4'b0111));
  a_r8_nop_when_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd == 4'b0111));
  a_r2_cke_stays: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(.HOLD_CYC(HOLD_CYC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .done(done)
);

// File: tb/sdram_powerup_seq_test.sv
module sdram_powerup_seq_test;
  localparam int CLK_NS  = 10;
  localparam int CLK_PS  = CLK_NS * 1000;
  localparam int HOLD_NS = 500;
  localparam int TRP_NS  = 20;
  localparam int TRFC_NS = 75;
  localparam int TMRD    = 2;

  localparam int T_HOLD = (HOLD_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_RP   = (TRP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_RFC  = (TRFC_NS * 1000 + CLK_PS - 1) / CLK_PS;

  localparam int NEV = 5;
  localparam int EV_CYC [NEV] = '{T_HOLD, T_HOLD + T_RP, T_HOLD + T_RP + T_RFC,
                                  T_HOLD + T_RP + 2 * T_RFC, T_HOLD + T_RP + 2 * T_RFC + TMRD};
  localparam logic [3:0] EV_CMD [NEV] = '{4'b0010, 4'b0001, 4'b0001, 4'b0000, 4'b0111};
  localparam int T_DONE = EV_CYC[4];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mode_word = 12'h000;
  logic        cke, cs_n, ras_n, cas_n, we_n, done;
  logic [11:0] addr;
  logic [1:0]  ba;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          finished = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  sdram_powerup_seq #(.CLK_PS(CLK_PS), .HOLD_NS(HOLD_NS), .TRP_NS(TRP_NS),
                      .TRFC_NS(TRFC_NS), .TMRD_CYC(TMRD)) uut (
    .clk(clk), .rst(rst), .mode_word(mode_word), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_cycle(input int i, input logic [11:0] m);
    logic [3:0]  ecmd = 4'b0111;
    logic [11:0] eaddr = 12'h000;
    logic [3:0]  cmd = {cs_n, ras_n, cas_n, we_n};
    for (int e = 0; e < NEV; e++)
      if (EV_CYC[e] == i) ecmd = EV_CMD[e];
    if (i == EV_CYC[0]) eaddr = 12'h400;
    if (i == EV_CYC[3]) eaddr = m & 12'h27F;
    chk(cmd == ecmd, (i <= T_HOLD) ? "R3" : (i < EV_CYC[3]) ? "R5" : "R8",
        $sformatf("cmd@%0d", i), cmd, ecmd);
    chk(addr == eaddr && ba == 2'b00, (i == EV_CYC[0]) ? "R4" : (i == EV_CYC[3]) ? "R6" : "R8",
        $sformatf("addr@%0d", i), addr, eaddr);
    chk(cke == (i > 0), "R2", $sformatf("cke@%0d", i), cke, (i > 0));
    chk(done == (i >= T_DONE), "R7", $sformatf("done@%0d", i), done, (i >= T_DONE));
  endtask

  task automatic run_seq(input logic [11:0] m, input int last);
    mode_word = m;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check_cycle(0, m);
    for (int i = 1; i <= last; i++) begin
      @(negedge clk);
      check_cycle(i, m);
    end
  endtask

  task automatic reset_check();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && !cke && !done && addr == 0 && ba == 0,
        "R1", "reset state", {cs_n, ras_n, cas_n, we_n, cke, done}, 6'b011100);
  endtask

  initial begin
    reset_check();
    // R9: TRFC_NS=75 at 10 ns must round up to 8 cycles
    chk(T_RFC == 8, "R9", "rounded refresh gap", T_RFC, 8);
    run_seq(12'hFFF, T_DONE + 40);
    reset_check();
    run_seq(12'h5A3, T_DONE + 5);
    // R10: reset inside the refresh window, then full restart
    reset_check();
    run_seq(12'h0D8, EV_CYC[1] + 3);
    reset_check();
    run_seq(12'h123, T_DONE + 10);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule